// File: doc/BRIEF.md
# External Vertical Sync Loss Monitor

This block supervises an external vertical sync signal while the display controller is locked to it. Once per vertical period a rising edge of that signal is expected. The block counts horizontal line ticks from the last detected edge and compares the count against a programmable period length. When the period runs out with no edge, it raises an error bit.

The error bit is sticky. It holds its value until one of two independent clear paths resets it: the display-reset control or a dedicated clear pulse. Supervision runs only while the external-sync mode enable is high. The external signal is asynchronous, so it passes through a synchronizer chain before the edge detector. The status bit is read-only and is 0 after reset.

Top module: `vsync_loss_monitor`

## Requirements
- R1: After reset `sync_err_o` is 0.
- R2: `vsync_ext_i` passes through two synchronizer flops before edge detection. A rise applied before clock edge k restarts the window at clock edge k+2.
- R3: Each window starts with a count of 0, and every cycle with `line_tick_i` high adds one line. If the cycle that brings the count up to `period_i` has no detected edge, the window expires. The count restarts and `sync_err_o` reads 1 after that clock edge.
- R4: A detected rising edge restarts the window count at 0. This also applies when a line tick falls in the same cycle, and no expiry occurs in that cycle.
- R5: Once set, `sync_err_o` stays 1 while neither `disp_reset_i` nor `flag_clr_i` is asserted.
- R6: A cycle with `flag_clr_i` high and no expiry makes `sync_err_o` 0 after that clock edge.
- R7: A cycle with `disp_reset_i` high and no expiry makes `sync_err_o` 0 after that clock edge.
- R8: If an expiry and a clear (either path) fall in the same cycle, `sync_err_o` is 1 afterwards.
- R9: While `tvsync_en_i` is 0, the window count is held at 0 and no expiry happens, so the flag can only be cleared. After the enable rises, a full `period_i` ticks are needed before an expiry.
- R10: A `period_i` of 0 behaves like 1: the first line tick of a window with no edge expires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync_ext_i | input | 1 | External vertical sync, asynchronous |
| line_tick_i | input | 1 | One-cycle pulse per horizontal line |
| period_i | input | PERIOD_W | Vertical period in lines |
| tvsync_en_i | input | 1 | External-sync supervision enable |
| disp_reset_i | input | 1 | Display reset, clears the error flag |
| flag_clr_i | input | 1 | Dedicated clear pulse for the error flag |
| sync_err_o | output | 1 | Sticky missing-sync error flag |

## Verification
The error bit reacts one clock edge after the cycle that decides it: an expiring tick, a clear pulse or a display reset. A rise on the external input reaches the window counter two edges after it is applied and acts at the third. The bench drives every input on the falling clock edge and reads the output on the next falling edge, which is half a cycle after the edge that updated it. A cycle-level reference model, written from the requirements, advances once per rising edge. Directed sequences add hand-counted expectations for the expiry cycle, the synchronizer latency and the clear/set collisions.

// File: rtl/vslm_pkg.sv
package vslm_pkg;

    // action taken by the period window counter in one cycle
    typedef enum logic [2:0] {
        WIN_IDLE    = 3'd0,   // supervision off, count forced to zero
        WIN_RESTART = 3'd1,   // edge seen, window starts again
        WIN_ADVANCE = 3'd2,   // line tick inside the window
        WIN_EXPIRE  = 3'd3,   // tick reached the period with no edge
        WIN_WAIT    = 3'd4    // nothing happened this cycle
    } win_act_e;

    typedef struct packed {
        logic err;
    } flag_state_t;

endpackage

// File: rtl/vslm_edge_sync.sv
module vslm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.chain = {state_q.chain[STAGES-2:0], async_i};
        state_d.last  = state_q.chain[STAGES-1];
        rise_o        = state_q.chain[STAGES-1] & ~state_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/vslm_window.sv
module vslm_window
    import vslm_pkg::*;
#(
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                tick_i,
    input  logic                rise_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                expire_o,
    output logic [PERIOD_W-1:0] count_o
);

    localparam int WIDE_W = PERIOD_W + 1;

    typedef struct packed {
        logic [PERIOD_W-1:0] count;
    } win_state_t;

    win_state_t          state_d, state_q;
    win_act_e            act;
    logic [WIDE_W-1:0]   next_count;

    always_comb begin
        next_count = {1'b0, state_q.count} + WIDE_W'(1);
        if (!en_i) begin
            act = WIN_IDLE;
        end else if (rise_i) begin
            act = WIN_RESTART;
        end else if (tick_i) begin
            if (next_count >= {1'b0, period_i}) begin
                act = WIN_EXPIRE;
            end else begin
                act = WIN_ADVANCE;
            end
        end else begin
            act = WIN_WAIT;
        end

        state_d = state_q;
        unique case (act)
            WIN_IDLE, WIN_RESTART, WIN_EXPIRE: state_d.count = '0;
            WIN_ADVANCE: state_d.count = next_count[PERIOD_W-1:0];
            default:     state_d.count = state_q.count;
        endcase

        expire_o = (act == WIN_EXPIRE);
        count_o  = state_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/vslm_flag.sv
module vslm_flag
    import vslm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic reset_clr_i,
    input  logic cmd_clr_i,
    output logic flag_o
);

    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_i) begin
            state_d.err = 1'b1;
        end else if (reset_clr_i || cmd_clr_i) begin
            state_d.err = 1'b0;
        end
        flag_o = state_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/vsync_loss_monitor.sv
module vsync_loss_monitor #(
    parameter int PERIOD_W    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vsync_ext_i,
    input  logic                line_tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                tvsync_en_i,
    input  logic                disp_reset_i,
    input  logic                flag_clr_i,
    output logic                sync_err_o
);

    logic                rise_w;
    logic                expire_w;
    logic [PERIOD_W-1:0] win_count_w;

    vslm_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (vsync_ext_i),
        .rise_o  (rise_w)
    );

    vslm_window #(
        .PERIOD_W (PERIOD_W)
    ) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tvsync_en_i),
        .tick_i   (line_tick_i),
        .rise_i   (rise_w),
        .period_i (period_i),
        .expire_o (expire_w),
        .count_o  (win_count_w)
    );

    vslm_flag i_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (expire_w),
        .reset_clr_i (disp_reset_i),
        .cmd_clr_i   (flag_clr_i),
        .flag_o      (sync_err_o)
    );

endmodule

// File: rtl/vslm_checker.sv
module vslm_checker #(
    parameter int PERIOD_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tvsync_en_i,
    input logic                disp_reset_i,
    input logic                flag_clr_i,
    input logic                sync_err_o,
    input logic                expire,
    input logic [PERIOD_W-1:0] win_count
);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err_o && !disp_reset_i && !flag_clr_i) |=> sync_err_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sync_err_o);

    // R6
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !expire) |=> !sync_err_o);

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_reset_i && !expire) |=> !sync_err_o);

    // R9
    idle_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tvsync_en_i && !sync_err_o) |=> !sync_err_o);

    // R9
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tvsync_en_i |=> (win_count == '0));

    // R3
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err_o) |-> $past(expire));

endmodule

bind vsync_loss_monitor vslm_checker #(
    .PERIOD_W (PERIOD_W)
) i_vslm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tvsync_en_i  (tvsync_en_i),
    .disp_reset_i (disp_reset_i),
    .flag_clr_i   (flag_clr_i),
    .sync_err_o   (sync_err_o),
    .expire       (expire_w),
    .win_count    (win_count_w)
);

// File: tb/test_vsync_loss_monitor.sv
module test_vsync_loss_monitor;

    localparam int  PW       = 12;
    localparam time CLK_T    = 10ns;
    localparam int  WD_LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vs = 1'b0;
    logic          tick = 1'b0;
    logic [PW-1:0] per = '0;
    logic          en = 1'b0;
    logic          dres = 1'b0;
    logic          fclr = 1'b0;
    logic          err;

    int total = 0;
    int bad   = 0;

    // reference state
    int m_s1 = 0, m_s2 = 0, m_last = 0, m_cnt = 0, m_flag = 0;

    always #(CLK_T/2) clk = ~clk;

    vsync_loss_monitor #(.PERIOD_W(PW)) i_vsync_loss_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .vsync_ext_i  (vs),
        .line_tick_i  (tick),
        .period_i     (per),
        .tvsync_en_i  (en),
        .disp_reset_i (dres),
        .flag_clr_i   (fclr),
        .sync_err_o   (err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: sync_err_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_edge();
        int rise;
        int expd;
        rise = (m_s2 != 0 && m_last == 0) ? 1 : 0;
        expd = 0;
        if (!en) m_cnt = 0;
        else if (rise != 0) m_cnt = 0;
        else if (tick) begin
            if (m_cnt + 1 >= int'(per)) begin
                expd  = 1;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        if (expd != 0) m_flag = 1;
        else if (dres || fclr) m_flag = 0;
        m_last = m_s2;
        m_s2   = m_s1;
        m_s1   = vs ? 1 : 0;
    endfunction

    // inputs are applied at the falling edge; returns at the next falling edge
    task automatic step(input logic v, input logic t, input logic c, input logic r);
        vs = v; tick = t; fclr = c; dres = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_T * WD_LIMIT);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        per = PW'(4);
        en  = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 reset", err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", err, 1'b0);

        // R3: four ticks with no edge expire a period of 4
        repeat (3) step(0, 1, 0, 0);
        chk("R3 before expiry", err, 1'b0);
        step(0, 1, 0, 0);
        chk("R3 expiry", err, 1'b1);

        // R5: flag holds without clears
        repeat (6) step(0, 0, 0, 0);
        chk("R5 sticky", err, 1'b1);

        // R6: dedicated clear
        step(0, 0, 1, 0);
        chk("R6 cmd clear", err, 1'b0);

        // R8: expiry and clear collide
        repeat (3) step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        chk("R8 set wins over clear", err, 1'b1);

        // R7: display reset clears
        step(0, 0, 0, 1);
        chk("R7 display reset clear", err, 1'b0);

        // R8: expiry and display reset collide
        repeat (3) step(0, 1, 0, 0);
        step(0, 1, 0, 1);
        chk("R8 set wins over reset", err, 1'b1);
        step(0, 0, 1, 0);

        // R2: rise applied now acts at the third edge, in time to stop expiry
        repeat (3) step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        chk("R2 sync latency", err, 1'b0);

        // R4: window restarted, three more ticks stay quiet, fourth expires
        repeat (3) step(1, 1, 0, 0);
        chk("R4 restart", err, 1'b0);
        step(0, 1, 0, 0);
        chk("R4 expiry after restart", err, 1'b1);

        // R9: disabled holds flag, then no set while cleared
        en = 1'b0;
        repeat (10) step(0, 1, 0, 0);
        chk("R9 hold while disabled", err, 1'b1);
        step(0, 1, 1, 0);
        repeat (10) step(0, 1, 0, 0);
        chk("R9 no set while disabled", err, 1'b0);
        en = 1'b1;
        repeat (3) step(0, 1, 0, 0);
        chk("R9 restart on enable", err, 1'b0);
        step(0, 1, 0, 0);
        chk("R9 expiry after enable", err, 1'b1);

        // R10: zero period expires on the first tick
        step(0, 0, 1, 0);
        per = '0;
        step(0, 0, 0, 0);
        chk("R10 no tick no expiry", err, 1'b0);
        step(0, 1, 0, 0);
        chk("R10 zero period", err, 1'b1);

        // random phase against the reference model (R3 R4 R5 R6 R7 R8 R9)
        void'($urandom(32'h5eed_0017));
        for (int i = 0; i < 4000; i++) begin
            logic nv, nt, nc, nr;
            if ((i % 200) == 0) per = PW'(2 + ($urandom % 7));
            en = ($urandom % 16) != 0;
            nv = ($urandom % 6) == 0 ? ~vs : vs;
            nt = ($urandom % 2) == 0;
            nc = ($urandom % 25) == 0;
            nr = ($urandom % 40) == 0;
            step(nv, nt, nc, nr);
            chk("R3/R5 random model", err, m_flag != 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule